// File: doc/BRIEF.md
# Pipelined 64-bit Integer Multiplier

This unit performs integer multiplication in the execute stage of a 64-bit processor. Each cycle it can take a new operation: two 65-bit operands, a 2-bit operation code, a destination register number and a flag that asks for a condition-field update. A fixed number of cycles later the result comes out with a valid flag, a register write enable, the register number, the 64-bit data and, when requested, a 32-bit condition word.

Signedness is not a control input. Decode prepares the operands so that bit 64 already holds the correct extension. It copies bit 63 for signed forms and is zero for unsigned forms. Narrower signed sources, such as a 16-bit immediate or a 32-bit word, arrive sign-extended across all 65 bits. A single signed multiplier therefore covers every form. The operation code only chooses which slice of the product is written back.

The pipeline never stalls. Each stage holds its own valid bit and control fields, so operations of different kinds can follow one another on consecutive cycles.

Top module: `imul_pipe`

## Requirements
- R1: `out_valid` rises in the cycle that follows the LATENCY-th rising edge counted from, and including, the edge that samples `in_valid` high. LATENCY is a parameter, default 4, minimum 3. `out_valid` stays low on every cycle that has no such issued operation.
- R2: While `rst_n` is low, and after it is released, `out_valid`, `out_wr_en` and `out_cr_en` stay low until a valid input issued after the release reaches the output. Inputs marked valid during reset produce no output.
- R3: Operands are read as 65-bit two's-complement values, with bit 64 acting as the extension bit. Operation codes 0 and 3 return bits 63:0 of the product. This covers signed and unsigned doubleword, word and sign-extended 16-bit immediate multiplies.
- R4: Operation code 1 returns bits 127:64 of the 65x65 product. The form is signed when bit 64 copies bit 63 and unsigned when bit 64 is zero.
- R5: Operation code 2 takes operands that are extended from bits 31:0. It returns the upper 32 bits of their 64-bit product, placed in both `out_data[31:0]` and `out_data[63:32]`. This covers signed and unsigned word forms.
- R6: `out_rd` equals the `in_rd` that was issued with the operation. `out_wr_en` equals `out_valid` in every cycle.
- R7: `out_cr_en` is high exactly when `out_valid` is high and the operation was issued with `in_cr_req` high.
- R8: When `out_cr_en` is high, `out_cr_data[31:28]` is 0x8 if `out_data` is negative as a signed 64-bit value, 0x2 if it is zero and 0x4 otherwise. Bits 27:0 are zero. A positive product therefore gives 0x40000000.
- R9: One operation is accepted in each cycle with no stall. Back-to-back operations of different codes keep their own results, register numbers and condition requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | An operation is issued this cycle |
| in_op | input | 2 | Result selection: 0/3 low 64, 1 high 64, 2 high 32 (replicated) |
| in_opnd_a | input | DATA_W+1 | First operand, bit 64 is the extension bit |
| in_opnd_b | input | DATA_W+1 | Second operand, bit 64 is the extension bit |
| in_rd | input | REG_W | Destination register number |
| in_cr_req | input | 1 | Request a condition-field update |
| out_valid | output | 1 | A result is present |
| out_wr_en | output | 1 | Register write enable |
| out_rd | output | REG_W | Destination register number of the result |
| out_data | output | DATA_W | Result data |
| out_cr_en | output | 1 | Condition-field write enable |
| out_cr_data | output | CR_W | Condition word, field in bits 31:28 |

## Verification
Every result is due in the cycle after the LATENCY-th rising edge that follows its issue. For the default of 4, that is four edges after the negedge at which the bench drives the operation. The driver stamps each expected item with that due cycle, counted by a free-running edge counter. The monitor samples at every falling edge. A front item that is due must be matched there, with its data, register number and condition fields. Any other cycle must show all write enables low, so a result that arrives early, late or twice is caught in the very cycle it appears.

// File: rtl/imul_pkg.sv
package imul_pkg;

  // Result-selection codes carried with every operation
  typedef enum logic [1:0] {
    OPC_LO64     = 2'd0,
    OPC_HI64     = 2'd1,
    OPC_HI32     = 2'd2,
    OPC_LO64_ALT = 2'd3
  } imul_opc_e;

  // Condition field codes (top nibble of the condition word)
  localparam logic [3:0] CRF_NEG  = 4'h8;
  localparam logic [3:0] CRF_POS  = 4'h4;
  localparam logic [3:0] CRF_ZERO = 4'h2;

endpackage

// File: rtl/imul_rst_sync.sv
module imul_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/imul_ctl_pipe.sv
// Control shift pipeline: valid chain under reset, fields clock-enabled.
module imul_ctl_pipe
  import imul_pkg::*;
#(
  parameter int DEPTH = 3,
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  imul_opc_e        in_op,
  input  logic [REG_W-1:0] in_rd,
  input  logic             in_cr_req,
  output logic [DEPTH-1:0] stg_vld,
  output imul_opc_e        tail_op,
  output logic [REG_W-1:0] tail_rd,
  output logic             tail_cr_req
);

  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] vld_d;
  imul_opc_e        op_q  [DEPTH];
  logic [REG_W-1:0] rd_q  [DEPTH];
  logic [DEPTH-1:0] crq_q;

  always_comb begin
    vld_d[0] = in_valid;
    for (int k = 1; k < DEPTH; k++) begin
      vld_d[k] = vld_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  // Payload registers only load when a valid item moves into the stage
  always_ff @(posedge clk) begin
    if (in_valid) begin
      op_q[0]  <= in_op;
      rd_q[0]  <= in_rd;
      crq_q[0] <= in_cr_req;
    end
    for (int k = 1; k < DEPTH; k++) begin
      if (vld_q[k-1]) begin
        op_q[k]  <= op_q[k-1];
        rd_q[k]  <= rd_q[k-1];
        crq_q[k] <= crq_q[k-1];
      end
    end
  end

  assign stg_vld     = vld_q;
  assign tail_op     = op_q[DEPTH-1];
  assign tail_rd     = rd_q[DEPTH-1];
  assign tail_cr_req = crq_q[DEPTH-1];

endmodule

// File: rtl/imul_mul_core.sv
// Operand capture, one signed multiply stage, then plain delay stages.
module imul_mul_core #(
  parameter int DATA_W  = 64,
  parameter int LATENCY = 4,
  localparam int OPND_W = DATA_W + 1,
  localparam int PROD_W = 2 * DATA_W,
  localparam int EXT_W  = PROD_W - OPND_W,
  localparam int NDLY   = LATENCY - 3
) (
  input  logic              clk,
  input  logic              in_valid,
  input  logic [OPND_W-1:0] opnd_a,
  input  logic [OPND_W-1:0] opnd_b,
  input  logic [NDLY:0]     stg_vld,
  output logic [PROD_W-1:0] prod
);

  logic [OPND_W-1:0]        a_q;
  logic [OPND_W-1:0]        b_q;
  logic signed [PROD_W-1:0] a_ext;
  logic signed [PROD_W-1:0] b_ext;
  logic signed [PROD_W-1:0] prod_d;

  always_ff @(posedge clk) begin
    if (in_valid) begin
      a_q <= opnd_a;
      b_q <= opnd_b;
    end
  end

  // Low PROD_W bits of the full 2*OPND_W signed product
  always_comb begin
    a_ext  = $signed({{EXT_W{a_q[OPND_W-1]}}, a_q});
    b_ext  = $signed({{EXT_W{b_q[OPND_W-1]}}, b_q});
    prod_d = a_ext * b_ext;
  end

  genvar g;
  generate
    for (g = 0; g <= NDLY; g++) begin : g_p
      logic [PROD_W-1:0] q;
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (stg_vld[0]) begin
            q <= prod_d;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (stg_vld[g]) begin
            q <= g_p[g-1].q;
          end
        end
      end
    end
  endgenerate

  assign prod = g_p[NDLY].q;

endmodule

// File: rtl/imul_result_sel.sv
// Picks the product slice for the operation and forms the condition word.
module imul_result_sel
  import imul_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CR_W   = 32,
  localparam int PROD_W = 2 * DATA_W,
  localparam int HALF   = DATA_W / 2
) (
  input  imul_opc_e         op,
  input  logic [PROD_W-1:0] prod,
  output logic [DATA_W-1:0] res_data,
  output logic [CR_W-1:0]   res_cr
);

  logic [3:0] field;

  always_comb begin
    unique case (op)
      OPC_HI64: res_data = prod[PROD_W-1:DATA_W];
      OPC_HI32: res_data = {2{prod[DATA_W-1:HALF]}};
      default:  res_data = prod[DATA_W-1:0];
    endcase
  end

  always_comb begin
    if (res_data[DATA_W-1]) begin
      field = CRF_NEG;
    end else if (res_data == '0) begin
      field = CRF_ZERO;
    end else begin
      field = CRF_POS;
    end
    res_cr = {field, {(CR_W-4){1'b0}}};
  end

endmodule

// File: rtl/imul_pipe.sv
module imul_pipe
  import imul_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int LATENCY = 4,
  parameter int REG_W   = 5,
  parameter int CR_W    = 32,
  localparam int OPND_W = DATA_W + 1,
  localparam int PROD_W = 2 * DATA_W,
  localparam int DEPTH  = LATENCY - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_op,
  input  logic [OPND_W-1:0] in_opnd_a,
  input  logic [OPND_W-1:0] in_opnd_b,
  input  logic [REG_W-1:0]  in_rd,
  input  logic              in_cr_req,
  output logic              out_valid,
  output logic              out_wr_en,
  output logic [REG_W-1:0]  out_rd,
  output logic [DATA_W-1:0] out_data,
  output logic              out_cr_en,
  output logic [CR_W-1:0]   out_cr_data
);

  logic              rst_sync_n;
  logic [DEPTH-1:0]  stg_vld;
  imul_opc_e         tail_op;
  logic [REG_W-1:0]  tail_rd;
  logic              tail_cr_req;
  logic [PROD_W-1:0] prod;
  logic [DATA_W-1:0] sel_data;
  logic [CR_W-1:0]   sel_cr;

  logic              valid_d, wr_en_d, cr_en_d;
  logic              valid_q, wr_en_q, cr_en_q;
  logic [REG_W-1:0]  rd_q;
  logic [DATA_W-1:0] data_q;
  logic [CR_W-1:0]   cr_q;

  imul_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_sync_n)
  );

  imul_ctl_pipe #(.DEPTH(DEPTH), .REG_W(REG_W)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .in_valid    (in_valid),
    .in_op       (imul_opc_e'(in_op)),
    .in_rd       (in_rd),
    .in_cr_req   (in_cr_req),
    .stg_vld     (stg_vld),
    .tail_op     (tail_op),
    .tail_rd     (tail_rd),
    .tail_cr_req (tail_cr_req)
  );

  imul_mul_core #(.DATA_W(DATA_W), .LATENCY(LATENCY)) u_core (
    .clk      (clk),
    .in_valid (in_valid),
    .opnd_a   (in_opnd_a),
    .opnd_b   (in_opnd_b),
    .stg_vld  (stg_vld[LATENCY-3:0]),
    .prod     (prod)
  );

  imul_result_sel #(.DATA_W(DATA_W), .CR_W(CR_W)) u_sel (
    .op       (tail_op),
    .prod     (prod),
    .res_data (sel_data),
    .res_cr   (sel_cr)
  );

  // Output stage: next-state logic
  always_comb begin
    valid_d = stg_vld[DEPTH-1];
    wr_en_d = stg_vld[DEPTH-1];
    cr_en_d = stg_vld[DEPTH-1] & tail_cr_req;
  end

  // Output stage: flags under reset
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      wr_en_q <= 1'b0;
      cr_en_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      wr_en_q <= wr_en_d;
      cr_en_q <= cr_en_d;
    end
  end

  // Output stage: payload with clock enable
  always_ff @(posedge clk) begin
    if (stg_vld[DEPTH-1]) begin
      rd_q   <= tail_rd;
      data_q <= sel_data;
      cr_q   <= sel_cr;
    end
  end

  assign out_valid   = valid_q;
  assign out_wr_en   = wr_en_q;
  assign out_rd      = rd_q;
  assign out_data    = data_q;
  assign out_cr_en   = cr_en_q;
  assign out_cr_data = cr_q;

endmodule

// File: rtl/imul_pipe_chk.sv
module imul_pipe_chk #(
  parameter int DATA_W  = 64,
  parameter int LATENCY = 4,
  parameter int REG_W   = 5,
  parameter int CR_W    = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        in_op,
  input logic [REG_W-1:0]  in_rd,
  input logic              in_cr_req,
  input logic              out_valid,
  input logic              out_wr_en,
  input logic [REG_W-1:0]  out_rd,
  input logic [DATA_W-1:0] out_data,
  input logic              out_cr_en,
  input logic [CR_W-1:0]   out_cr_data
);

  localparam int HALF = DATA_W / 2;

  logic [LATENCY-1:0] vld_sh;
  logic [LATENCY-1:0] hi32_sh;
  logic [LATENCY-1:0] crq_sh;
  logic [REG_W-1:0]   rd_sh [LATENCY];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_sh  <= '0;
      hi32_sh <= '0;
      crq_sh  <= '0;
    end else begin
      vld_sh  <= {vld_sh[LATENCY-2:0], in_valid};
      hi32_sh <= {hi32_sh[LATENCY-2:0], in_op == 2'd2};
      crq_sh  <= {crq_sh[LATENCY-2:0], in_cr_req};
    end
  end

  always_ff @(posedge clk) begin
    rd_sh[0] <= in_rd;
    for (int k = 1; k < LATENCY; k++) begin
      rd_sh[k] <= rd_sh[k-1];
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vld_sh[LATENCY-1]); // R1

  AST_WR_EN_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr_en == out_valid); // R6

  AST_RD_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_rd == rd_sh[LATENCY-1]); // R6

  AST_CR_EN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    out_cr_en == (out_valid && crq_sh[LATENCY-1])); // R7

  AST_CR_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    out_cr_en |-> ($onehot(out_cr_data[CR_W-1:CR_W-4]) && out_cr_data[CR_W-5:0] == '0)); // R8

  AST_CR_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    out_cr_en |-> (out_cr_data[CR_W-1] == out_data[DATA_W-1])); // R8

  AST_HI32_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && hi32_sh[LATENCY-1]) |-> out_data[DATA_W-1:HALF] == out_data[HALF-1:0]); // R5

endmodule

bind imul_pipe imul_pipe_chk #(
  .DATA_W(DATA_W), .LATENCY(LATENCY), .REG_W(REG_W), .CR_W(CR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .in_valid    (in_valid),
  .in_op       (in_op),
  .in_rd       (in_rd),
  .in_cr_req   (in_cr_req),
  .out_valid   (out_valid),
  .out_wr_en   (out_wr_en),
  .out_rd      (out_rd),
  .out_data    (out_data),
  .out_cr_en   (out_cr_en),
  .out_cr_data (out_cr_data)
);

// File: tb/tb_imul_pipe.sv
`timescale 1ns/1ps
module tb_imul_pipe;

  localparam int LAT = 4;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  in_op;
  logic [64:0] in_opnd_a;
  logic [64:0] in_opnd_b;
  logic [4:0]  in_rd;
  logic        in_cr_req;
  logic        out_valid;
  logic        out_wr_en;
  logic [4:0]  out_rd;
  logic [63:0] out_data;
  logic        out_cr_en;
  logic [31:0] out_cr_data;

  imul_pipe #(.DATA_W(64), .LATENCY(LAT), .REG_W(5), .CR_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_opnd_a(in_opnd_a), .in_opnd_b(in_opnd_b), .in_rd(in_rd),
    .in_cr_req(in_cr_req), .out_valid(out_valid), .out_wr_en(out_wr_en),
    .out_rd(out_rd), .out_data(out_data), .out_cr_en(out_cr_en),
    .out_cr_data(out_cr_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    int unsigned due;
    logic [4:0]  rd;
    logic [63:0] data;
    logic        cr_en;
    logic [31:0] cr;
    int          tag;
  } exp_t;

  exp_t        sb_q[$];
  int unsigned cyc = 0;
  int          checks = 0;
  int          errors = 0;
  bit          mon_en = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [127:0] mul128(logic [63:0] a, logic [63:0] b, bit sgn);
    logic signed [127:0] sa, sb, sp;
    if (sgn) begin
      sa = $signed({{64{a[63]}}, a});
      sb = $signed({{64{b[63]}}, b});
      sp = sa * sb;
      return sp;
    end
    return {64'd0, a} * {64'd0, b};
  endfunction

  function automatic logic [63:0] ext32(logic [63:0] v, bit sgn);
    return sgn ? {{32{v[31]}}, v[31:0]} : {32'd0, v[31:0]};
  endfunction

  // Expected result from the operation definitions (R3, R4, R5)
  function automatic logic [63:0] ref_res(logic [1:0] op, logic [63:0] a, logic [63:0] b, bit sgn);
    logic [127:0] p;
    if (op == 2'd2) begin
      p = mul128(ext32(a, sgn), ext32(b, sgn), sgn);
      return {p[63:32], p[63:32]};
    end
    p = mul128(a, b, sgn);
    return (op == 2'd1) ? p[127:64] : p[63:0];
  endfunction

  // Condition word (R8)
  function automatic logic [31:0] ref_cr(logic [63:0] d);
    if (d[63])      return 32'h8000_0000;
    if (d == 64'd0) return 32'h2000_0000;
    return 32'h4000_0000;
  endfunction

  task automatic chk(bit ok, int tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // Driver: one issue per negedge, expected item due LAT edges later
  task automatic issue(logic [1:0] op, logic [63:0] a, logic [63:0] b, bit sgn,
                       logic [4:0] rd, bit crq, int tag);
    exp_t it;
    logic [63:0] ax, bx;
    @(negedge clk);
    ax = (op == 2'd2) ? ext32(a, sgn) : a;
    bx = (op == 2'd2) ? ext32(b, sgn) : b;
    in_valid  = 1'b1;
    in_op     = op;
    in_opnd_a = {sgn & ax[63], ax};
    in_opnd_b = {sgn & bx[63], bx};
    in_rd     = rd;
    in_cr_req = crq;
    it.due   = cyc + LAT;
    it.rd    = rd;
    it.data  = ref_res(op, a, b, sgn);
    it.cr_en = crq;
    it.cr    = ref_cr(it.data);
    it.tag   = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid  = 1'b0;
      in_op     = 2'($urandom);
      in_opnd_a = {1'b0, $urandom, $urandom};
      in_opnd_b = {1'b0, $urandom, $urandom};
      in_rd     = 5'($urandom);
      in_cr_req = 1'b1;
    end
  endtask

  // Monitor
  always @(negedge clk) begin
    if (mon_en) begin
      if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
        exp_t it;
        it = sb_q.pop_front();
        chk(out_valid && out_wr_en, 1, "valid/wr_en on due cycle (R1 R6)",
            {62'd0, out_valid, out_wr_en}, 64'd3);
        chk(out_rd == it.rd, 6, "register number", {59'd0, out_rd}, {59'd0, it.rd});
        chk(out_data == it.data, it.tag, "result data", out_data, it.data);
        chk(out_cr_en == it.cr_en, 7, "condition enable", {63'd0, out_cr_en}, {63'd0, it.cr_en});
        if (it.cr_en) begin
          chk(out_cr_data == it.cr, 8, "condition word", {32'd0, out_cr_data}, {32'd0, it.cr});
        end
      end else begin
        chk(!out_valid && !out_wr_en && !out_cr_en, (rst_n ? 1 : 2), "idle cycle enables",
            {61'd0, out_valid, out_wr_en, out_cr_en}, 64'd0);
      end
    end
  end

  task automatic rnd_block(logic [1:0] op, bit sgn, bit imm16, int n, int tag);
    for (int i = 0; i < n; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (imm16) b = {{48{b[15]}}, b[15:0]};
      if (($urandom % 4) == 0) idle(1 + ($urandom % 3));
      issue(op, a, b, sgn, 5'($urandom), 1'($urandom), tag);
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_op = 2'd0;
    in_opnd_a = '0; in_opnd_b = '0; in_rd = '0; in_cr_req = 1'b0;
    repeat (3) @(negedge clk);
    mon_en = 1'b1;
    // R2: valid inputs during reset must not surface
    in_valid = 1'b1; in_cr_req = 1'b1; in_opnd_a = 65'd7; in_opnd_b = 65'd9;
    repeat (4) @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b1;
    idle(LAT + 3);   // R2: nothing appears after release

    // R3 and R8: directed low products, positive / negative / zero
    issue(2'd0, 64'h1000, 64'h1111, 1'b0, 5'd17, 1'b0, 3);
    idle(LAT + 1);   // R1: gaps stay quiet
    issue(2'd0, 64'h1000, 64'h1111, 1'b0, 5'd17, 1'b1, 3);
    issue(2'd0, -64'sd5, 64'd3, 1'b1, 5'd2, 1'b1, 8);
    issue(2'd0, 64'd0, 64'hDEAD_BEEF, 1'b1, 5'd3, 1'b1, 8);
    issue(2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 1'b0, 5'd4, 1'b1, 3);
    // R4 corners
    issue(2'd1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b1, 5'd5, 1'b1, 4);
    issue(2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 5'd6, 1'b1, 4);
    issue(2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b1, 5'd7, 1'b1, 4);
    // R5 corners
    issue(2'd2, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 1'b0, 5'd8, 1'b1, 5);
    issue(2'd2, 64'h8000_0000, 64'h7FFF_FFFF, 1'b1, 5'd9, 1'b1, 5);
    // R9: back-to-back mix of codes and register numbers
    issue(2'd1, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 1'b0, 5'd30, 1'b0, 9);
    issue(2'd2, 64'h0000_0000_F000_0001, 64'h0000_0000_0000_0010, 1'b1, 5'd31, 1'b1, 9);
    issue(2'd0, 64'h0000_0001_0000_0000, 64'h0000_0001_0000_0000, 1'b0, 5'd0, 1'b1, 9);
    idle(2);

    // Random blocks for each form
    rnd_block(2'd0, 1'b1, 1'b0, 150, 3);  // R3 signed doubleword
    rnd_block(2'd0, 1'b0, 1'b0, 100, 3);  // R3 unsigned
    rnd_block(2'd0, 1'b1, 1'b1, 100, 3);  // R3 sign-extended 16-bit immediate
    rnd_block(2'd1, 1'b1, 1'b0, 150, 4);  // R4 signed
    rnd_block(2'd1, 1'b0, 1'b0, 150, 4);  // R4 unsigned
    rnd_block(2'd2, 1'b1, 1'b0, 150, 5);  // R5 signed word
    rnd_block(2'd2, 1'b0, 1'b0, 150, 5);  // R5 unsigned word
    for (int i = 0; i < 100; i++) begin   // R9 mixed stream
      logic [1:0] op;
      op = 2'($urandom % 3);
      issue(op, {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom),
            5'($urandom), 1'($urandom), 9);
    end

    idle(1);
    while (sb_q.size() > 0) idle(1);
    idle(LAT + 2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual %0d cycles expected completion", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule